// File: doc/BRIEF.md
# Transactional Directory Sharer Responder

This block sits on the directory side of a cache-coherent multicore and serves the marking requests that cores issue for lines touched inside a transaction. These requests take the place of the ordinary shared and exclusive get requests. For every line the block holds one bit per core that records which cores have marked the line. When a core marks a line, the block answers that core with an acknowledgement. The acknowledgement carries the line and the number of other cores that already share it. The block then records the requester as a sharer.

When other sharers exist, the block emits one accessor notice per sharer. Each notice names the target sharer, the requesting core, the line and whether the access is a read or a write. A receiving core can then add the requester to its list of conflicting transactions, and it can discard read-read pairs. Notices leave one per cycle in ascending core order. While they are pending the block raises `busy`, and any new request offered in that time is dropped.

When a core ends or aborts its transaction, it pulses an end signal. That pulse clears the core's bit on every line. Marks on different lines never interact; the only shared resource is the single notice port.

Top module: `tx_sharer_dir`

## Requirements
- R1: After reset every sharer vector is empty, and `ack_valid`, `ntc_valid` and `busy` are low.
- R2: A request is accepted when `req_valid` is high and `busy` is low at a clock edge. In the next cycle `ack_valid` is high and `ack_core`/`ack_line` echo the request. `ack_count` equals the number of cores other than the requester whose bit is set for that line, and it is 0 when there are none.
- R3: After acceptance the requester's bit is set for the line. A repeated mark by the same core never counts the requester itself.
- R4: For each counted sharer, exactly one notice is issued. Notices appear one per cycle, starting in the cycle of the acknowledgement, in ascending target index. Each carries `ntc_requester`, `ntc_line` and `ntc_write` (1 = write, 0 = read) taken from the request.
- R5: `busy` is high exactly while notices remain. A request offered while `busy` is high produces no acknowledgement and leaves every sharer vector unchanged.
- R6: A cycle with `end_valid` high clears the bit of `end_core` on all lines, so later counts exclude that core.
- R7: A mark on one line neither reads nor alters the sharer vector of any other line.
- R8: When an end and an accepted mark occur in the same cycle, the clear is applied first. The ending core is neither counted nor sent a notice.
- R9: `ack_valid` is a single-cycle pulse per accepted request. `ntc_valid` is low whenever no notice is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Marking request present |
| req_core | input | CORE_W | Requesting core |
| req_line | input | LINE_W | Line being marked |
| req_write | input | 1 | 1 = write access, 0 = read access |
| end_valid | input | 1 | Transaction end or abort pulse |
| end_core | input | CORE_W | Core whose transaction ended |
| busy | output | 1 | Notice fan-out in progress; requests are dropped |
| ack_valid | output | 1 | Acknowledgement pulse |
| ack_core | output | CORE_W | Core being acknowledged |
| ack_line | output | LINE_W | Line being acknowledged |
| ack_count | output | CORE_W | Number of other sharers |
| ntc_valid | output | 1 | Accessor notice present |
| ntc_target | output | CORE_W | Sharer receiving the notice |
| ntc_requester | output | CORE_W | Core that made the access |
| ntc_line | output | LINE_W | Line concerned |
| ntc_write | output | 1 | Access kind of the requester |

## Verification
The acknowledgement is registered, so it is due in the cycle after the accepting edge. The first notice arrives in that same cycle, and each further notice arrives one cycle later, so a request with k other sharers keeps `busy` high for k cycles. The bench drives inputs on falling edges and samples one falling edge after the accepting edge. It then steps one falling edge per expected notice and checks for idle on the edge that follows the last notice. Expected counts and notice targets come from a bench-side table of sharer masks.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
    typedef enum logic {
        TSD_READ  = 1'b0,
        TSD_WRITE = 1'b1
    } tsd_access_e;
endpackage

// File: rtl/tsd_popcnt.sv
module tsd_popcnt #(
    parameter int W     = 4,
    parameter int OUT_W = 2
) (
    input  logic [W-1:0]     vec,
    output logic [OUT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + OUT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/tsd_first_one.sv
module tsd_first_one #(
    parameter int W     = 4,
    parameter int IDX_W = 2
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     rest
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        rest = vec & (vec - W'(1));
    end
endmodule

// File: rtl/tx_sharer_dir.sv
module tx_sharer_dir #(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CORE_W-1:0] req_core,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_write,
    input  logic              end_valid,
    input  logic [CORE_W-1:0] end_core,
    output logic              busy,
    output logic              ack_valid,
    output logic [CORE_W-1:0] ack_core,
    output logic [LINE_W-1:0] ack_line,
    output logic [CORE_W-1:0] ack_count,
    output logic              ntc_valid,
    output logic [CORE_W-1:0] ntc_target,
    output logic [CORE_W-1:0] ntc_requester,
    output logic [LINE_W-1:0] ntc_line,
    output logic              ntc_write
);
    import tsd_pkg::*;

    typedef logic [NUM_CORES-1:0] cmask_t;

    typedef struct packed {
        logic [NUM_LINES-1:0][NUM_CORES-1:0] sharers;
        cmask_t                              pending;
        logic [CORE_W-1:0]                   src;
        logic [LINE_W-1:0]                   line;
        tsd_access_e                         kind;
        logic                                ack_v;
        logic [CORE_W-1:0]                   ack_core;
        logic [LINE_W-1:0]                   ack_line;
        logic [CORE_W-1:0]                   ack_cnt;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0][NUM_CORES-1:0] after_end;
    cmask_t            end_mask, req_mask, line_vec, others, rest;
    logic [CORE_W-1:0] others_cnt, first_idx;
    logic              first_found, accept;

    tsd_popcnt #(.W(NUM_CORES), .OUT_W(CORE_W)) u_cnt (
        .vec (others),
        .cnt (others_cnt)
    );

    tsd_first_one #(.W(NUM_CORES), .IDX_W(CORE_W)) u_pick (
        .vec   (st_q.pending),
        .found (first_found),
        .idx   (first_idx),
        .rest  (rest)
    );

    always_comb begin
        end_mask = end_valid ? (cmask_t'(1) << end_core) : '0;
        req_mask = cmask_t'(1) << req_core;
        for (int l = 0; l < NUM_LINES; l++) begin
            after_end[l] = st_q.sharers[l] & ~end_mask;
        end
        line_vec = after_end[req_line];
        others   = line_vec & ~req_mask;
        accept   = req_valid && !first_found;

        st_d         = st_q;
        st_d.sharers = after_end;
        st_d.ack_v   = accept;
        st_d.pending = rest;
        if (accept) begin
            st_d.sharers[req_line] = line_vec | req_mask;
            st_d.pending           = others;
            st_d.src               = req_core;
            st_d.line              = req_line;
            st_d.kind              = tsd_access_e'(req_write);
            st_d.ack_core          = req_core;
            st_d.ack_line          = req_line;
            st_d.ack_cnt           = others_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = first_found;
    assign ack_valid     = st_q.ack_v;
    assign ack_core      = st_q.ack_core;
    assign ack_line      = st_q.ack_line;
    assign ack_count     = st_q.ack_cnt;
    assign ntc_valid     = first_found;
    assign ntc_target    = first_idx;
    assign ntc_requester = st_q.src;
    assign ntc_line      = st_q.line;
    assign ntc_write     = (st_q.kind == TSD_WRITE);
endmodule

// File: rtl/tx_sharer_dir_chk.sv
module tx_sharer_dir_chk #(
    parameter int CORE_W = 2,
    parameter int LINE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [CORE_W-1:0] req_core,
    input logic [LINE_W-1:0] req_line,
    input logic              busy,
    input logic              ack_valid,
    input logic [CORE_W-1:0] ack_core,
    input logic [LINE_W-1:0] ack_line,
    input logic [CORE_W-1:0] ack_count,
    input logic              ntc_valid,
    input logic [CORE_W-1:0] ntc_target
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !ack_valid && !ntc_valid && !busy);

    assert_ack_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> ack_valid && ack_core == $past(req_core)
                               && ack_line == $past(req_line));

    assert_zero_count_no_notice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && ack_count == '0 |-> !ntc_valid);

    assert_ascending_notice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ntc_valid && !ack_valid |-> $past(ntc_valid) && ntc_target > $past(ntc_target));

    assert_drop_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !busy) |=> !ack_valid);

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);
endmodule

bind tx_sharer_dir tx_sharer_dir_chk #(.CORE_W(CORE_W), .LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_core   (req_core),
    .req_line   (req_line),
    .busy       (busy),
    .ack_valid  (ack_valid),
    .ack_core   (ack_core),
    .ack_line   (ack_line),
    .ack_count  (ack_count),
    .ntc_valid  (ntc_valid),
    .ntc_target (ntc_target)
);

// File: tb/tx_sharer_dir_bench.sv
module tx_sharer_dir_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_core = '0;
    logic [2:0] req_line = '0;
    logic       req_write = 1'b0;
    logic       end_valid = 1'b0;
    logic [1:0] end_core = '0;
    logic       busy, ack_valid, ntc_valid, ntc_write;
    logic [1:0] ack_core, ack_count, ntc_target, ntc_requester;
    logic [2:0] ack_line, ntc_line;

    int checks = 0;
    int fails  = 0;
    logic [3:0] model [8];

    always #4 clk = ~clk;

    tx_sharer_dir u_tx_sharer_dir (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_line(req_line), .req_write(req_write), .end_valid(end_valid),
        .end_core(end_core), .busy(busy), .ack_valid(ack_valid),
        .ack_core(ack_core), .ack_line(ack_line), .ack_count(ack_count),
        .ntc_valid(ntc_valid), .ntc_target(ntc_target),
        .ntc_requester(ntc_requester), .ntc_line(ntc_line), .ntc_write(ntc_write)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic end_tx(input int c);
        @(negedge clk);
        end_valid = 1'b1;
        end_core  = 2'(c);
        @(negedge clk);
        end_valid = 1'b0;
        for (int l = 0; l < 8; l++) model[l][c] = 1'b0;
    endtask

    task automatic mark(input int c, input int l, input bit wr,
                        input bit with_end, input int ec, input string rq);
        logic [3:0] others;
        int cnt;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_core = 2'(c); req_line = 3'(l); req_write = wr;
        end_valid = with_end; end_core = 2'(ec);
        if (with_end) for (int k = 0; k < 8; k++) model[k][ec] = 1'b0;
        others = model[l] & ~(4'b1 << c);
        cnt = $countones(others);
        @(negedge clk);
        req_valid = 1'b0; end_valid = 1'b0;
        chk(ack_valid == 1'b1, "R2", int'(ack_valid), 1);
        chk(ack_core == 2'(c) && ack_line == 3'(l), "R2", int'(ack_core), c);
        chk(ack_count == 2'(cnt), rq, int'(ack_count), cnt);
        for (int t = 0; t < 4; t++) begin
            if (others[t]) begin
                chk(ntc_valid && ntc_target == 2'(t), "R4", int'(ntc_target), t);
                chk(ntc_requester == 2'(c) && ntc_line == 3'(l), "R4", int'(ntc_requester), c);
                chk(ntc_write == wr, "R4", int'(ntc_write), int'(wr));
                chk(busy == 1'b1, "R5", int'(busy), 1);
                @(negedge clk);
            end
        end
        chk(ntc_valid == 1'b0, "R9", int'(ntc_valid), 0);
        chk(busy == 1'b0, "R5", int'(busy), 0);
        if (others != 0) chk(ack_valid == 1'b0, "R9", int'(ack_valid), 0);
        model[l][c] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int l = 0; l < 8; l++) model[l] = '0;
        repeat (3) @(negedge clk);
        chk(!ack_valid && !ntc_valid && !busy, "R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ack_valid && !ntc_valid && !busy, "R1", int'(ntc_valid), 0);

        // R3: own bit never counted
        mark(0, 0, 1'b0, 1'b0, 0, "R2");
        mark(0, 0, 1'b1, 1'b0, 0, "R3");

        // R2/R4: growing sharer sets
        for (int l = 1; l < 4; l++)
            for (int c = 0; c < 4; c++)
                mark(c, l, c[0], 1'b0, 0, "R2");

        // R7: fresh line unaffected by full neighbours
        mark(1, 4, 1'b1, 1'b0, 0, "R7");

        // R6: end clears a core everywhere
        end_tx(2);
        mark(2, 1, 1'b0, 1'b0, 0, "R6");
        mark(0, 2, 1'b1, 1'b0, 0, "R6");

        // R8: same-cycle end and mark
        mark(0, 3, 1'b1, 1'b1, 1, "R8");

        // R5: request during fan-out is dropped
        mark(0, 5, 1'b0, 1'b0, 0, "R2");
        mark(1, 5, 1'b0, 1'b0, 0, "R2");
        mark(2, 5, 1'b1, 1'b0, 0, "R2");
        @(negedge clk);
        req_valid = 1'b1; req_core = 2'd3; req_line = 3'd5; req_write = 1'b0;
        @(negedge clk);
        req_line = 3'd6; req_write = 1'b1;
        chk(ack_valid && ack_count == 2'd3, "R5", int'(ack_count), 3);
        chk(busy == 1'b1, "R5", int'(busy), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ack_valid == 1'b0, "R5", int'(ack_valid), 0);
        while (busy) @(negedge clk);
        model[5][3] = 1'b1;
        mark(0, 6, 1'b0, 1'b0, 0, "R5");

        // Sweep of every sharer subset on line 7
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 4; c++) end_tx(c);
            for (int c = 0; c < 4; c++)
                if (m[c]) mark(c, 7, 1'b0, 1'b0, 0, "R2");
            mark(m % 4, 7, m[0], 1'b0, 0, "R4");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule